// File: doc/BRIEF.md
# Dual-Bank Flash Command Interface

This block is the host-facing command logic of a two-bank NOR flash, with a small behavioural word array. The host drives chip enable, write enable, output enable, a word address and 16-bit write data. All of these are sampled on a system clock. A write is taken when write enable rises while chip enable is low. The block decodes the multi-cycle command sequences and starts program and erase jobs toward an external sequencer over a request/done handshake. The ready/busy pin is held low until a job and its array update have completed.

The address space is split into two banks. The main bank holds fourteen large sectors. The boot bank holds eight small sectors at the top of the space. While one bank is busy, reads to the other bank return array data combinationally, with no wait. Reads to the busy bank return a status word instead. An unlock-bypass mode shortens a program to two writes. When a job ends, the block returns to array reads without any host command.

Top module: `dual_bank_flash_cmd`

## Requirements
- R1: When `rst_n` is low, `ry_by` is 1 and `job_req` is 0 at the next clock edge. Any job in progress is abandoned and the decoder returns to array-read mode, which also leaves bypass mode. With `oen` high, `dq_oe` is 0.
- R2: A normal program is four writes: 0x00AA to word 0x555, 0x0055 to word 0x2AA, 0x00A0 to word 0x555, then the target address and data. Only the low byte of each command write is decoded. After the fourth write, `job_req` is 1 with `job_op`=01, `job_addr` and `job_data` set, and `ry_by` is 0. These stay stable until `job_done`.
- R3: On `job_done` for a program, the target word becomes its old value AND the program data.
- R4: Sector erase is AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 0x30 to any word of the sector, with `job_op`=10. Chip erase ends instead with 0x10 to word 0x555, with `job_op`=11. Sectors are words 0..1791 in fourteen 128-word sectors (main bank) and words 1792..2047 in eight 32-word sectors (boot bank). After completion the erased range reads 0xFFFF and every other word is unchanged.
- R5: While a job targets one bank, a read of the other bank returns its array word immediately. Chip erase makes both banks busy.
- R6: A read of a busy bank returns a status word. Bits 15:8 and 5:0 are 0. Bit 7 is the inverse of bit 7 of the program data, or 0 during an erase. Bit 6 starts at 0 for each job and inverts after each read of the busy bank, counted at the rise of `oen`.
- R7: Once a job and its array update finish, `ry_by` returns to 1 and reads return array data with no further command.
- R8: AA@555, 55@2AA, 0x20@555 enters bypass mode. In bypass, 0xA0 to any address followed by the address/data write starts a program, and the block stays in bypass afterwards. 0x90 then 0x00 leaves bypass. After that, a two-write program starts nothing.
- R9: Outside bypass, a write that breaks the expected sequence step returns the decoder to array-read mode. A 0xF0 write does the same, so the sequence must restart from its first write.
- R10: Writes issued while a job is in progress start no job and leave the array unchanged.
- R11: A write-enable pulse while `cen` is high is ignored and does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the bus |
| rst_n | input | 1 | Active-low reset, aborts any job |
| cen | input | 1 | Chip enable, active low |
| wen | input | 1 | Write enable, active low; write taken on its rise |
| oen | input | 1 | Output enable, active low |
| addr | input | 11 | Word address |
| dq_in | input | 16 | Write data from host |
| dq_out | output | 16 | Read data: array word or status |
| dq_oe | output | 1 | Read data drive enable |
| ry_by | output | 1 | High when ready, low while a job runs |
| job_req | output | 1 | Job request to sequencer, held until done |
| job_op | output | 2 | 01 program, 10 sector erase, 11 chip erase |
| job_addr | output | 11 | Target word or sector address |
| job_data | output | 16 | Program data |
| job_done | input | 1 | One-cycle completion from sequencer |

## Verification
The hardest situation to reach is a read of one bank during a job on the other bank. It has to land while the request is still open, and the status toggle has to be seen advancing across two reads. The bench's sequencer model holds `job_done` back until released. For each of many addresses in both banks, it reads the opposite bank and then the busy bank twice before releasing the job. The same hold is used to issue writes during a job and to apply reset in the middle of one.

// File: rtl/dual_bank_flash_cmd.sv
module dual_bank_flash_cmd #(
  parameter int BIG_W   = 7,
  parameter int BIG_N   = 14,
  parameter int SMALL_W = 5,
  parameter int SMALL_N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cen,
  input  logic                 wen,
  input  logic                 oen,
  input  logic [10:0]          addr,
  input  logic [15:0]          dq_in,
  output logic [15:0]          dq_out,
  output logic                 dq_oe,
  output logic                 ry_by,
  output logic                 job_req,
  output logic [1:0]           job_op,
  output logic [10:0]          job_addr,
  output logic [15:0]          job_data,
  input  logic                 job_done
);
  localparam int BIG_TOTAL = BIG_N << BIG_W;
  localparam int WORDS     = BIG_TOTAL + (SMALL_N << SMALL_W);
  localparam int AW        = 11;
  localparam logic [AW-1:0] BOOT_BASE = AW'(BIG_TOTAL);
  localparam logic [AW-1:0] LAST_WORD = AW'(WORDS - 1);
  localparam logic [AW-1:0] BIG_MASK  = AW'((1 << BIG_W) - 1);
  localparam logic [AW-1:0] SMALL_MASK = AW'((1 << SMALL_W) - 1);

  localparam logic [AW-1:0] A_555 = 11'h555;
  localparam logic [AW-1:0] A_2AA = 11'h2AA;
  localparam logic [7:0] C_AA = 8'hAA, C_55 = 8'h55, C_A0 = 8'hA0, C_80 = 8'h80;
  localparam logic [7:0] C_20 = 8'h20, C_30 = 8'h30, C_10 = 8'h10, C_90 = 8'h90;
  localparam logic [7:0] C_00 = 8'h00;
  localparam logic [1:0] OP_PGM = 2'b01, OP_SEC = 2'b10, OP_CHIP = 2'b11;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS1, ST_ERS2, ST_ERS3, ST_BYP, ST_BYPX
  } st_t;

  st_t st;
  logic byp, busy, clearing, busy_main, busy_boot, tog;
  logic wen_q, oen_q;
  logic [AW-1:0] clr_ptr, clr_hi;
  logic [15:0] mem [WORDS];

  logic [7:0] cmd;
  logic wr_stb, rd_end, hit_busy, cmd_at_555;
  logic mem_we;
  logic [AW-1:0] mem_wa;
  logic [15:0] mem_wd;

  function automatic logic [AW-1:0] sec_lo(input logic [AW-1:0] a);
    return (a < BOOT_BASE) ? (a & ~BIG_MASK) : (a & ~SMALL_MASK);
  endfunction

  function automatic logic [AW-1:0] sec_hi(input logic [AW-1:0] a);
    return (a < BOOT_BASE) ? (a | BIG_MASK) : (a | SMALL_MASK);
  endfunction

  assign cmd        = dq_in[7:0];
  assign cmd_at_555 = (addr == A_555);
  assign wr_stb     = wen & ~wen_q & ~cen;
  assign rd_end     = oen & ~oen_q & ~cen;
  assign hit_busy   = (addr >= BOOT_BASE) ? busy_boot : busy_main;

  assign ry_by   = ~busy;
  assign job_req = busy & ~clearing;
  assign dq_oe   = ~cen & ~oen;
  assign dq_out  = hit_busy ? {8'h00, (job_op == OP_PGM) & ~job_data[7], tog, 6'h00}
                            : mem[addr];

  assign mem_we = rst_n & busy & (clearing | (job_done & (job_op == OP_PGM)));
  assign mem_wa = clearing ? clr_ptr : job_addr;
  assign mem_wd = clearing ? 16'hFFFF : (mem[job_addr] & job_data);

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_READ;
      byp       <= 1'b0;
      busy      <= 1'b0;
      clearing  <= 1'b0;
      busy_main <= 1'b0;
      busy_boot <= 1'b0;
      tog       <= 1'b0;
      wen_q     <= 1'b1;
      oen_q     <= 1'b1;
      job_op    <= OP_PGM;
      job_addr  <= '0;
      job_data  <= '0;
      clr_ptr   <= '0;
      clr_hi    <= '0;
    end else begin
      wen_q <= wen;
      oen_q <= oen;
      if (rd_end && hit_busy) tog <= ~tog;
      if (busy) begin
        if (clearing) begin
          if (clr_ptr == clr_hi) begin
            busy      <= 1'b0;
            clearing  <= 1'b0;
            busy_main <= 1'b0;
            busy_boot <= 1'b0;
          end else begin
            clr_ptr <= clr_ptr + 1'b1;
          end
        end else if (job_done) begin
          if (job_op == OP_PGM) begin
            busy      <= 1'b0;
            busy_main <= 1'b0;
            busy_boot <= 1'b0;
          end else begin
            clearing <= 1'b1;
          end
        end
      end else if (wr_stb) begin
        case (st)
          ST_READ: st <= (cmd_at_555 && cmd == C_AA) ? ST_UNL1 : ST_READ;
          ST_UNL1: st <= (addr == A_2AA && cmd == C_55) ? ST_UNL2 : ST_READ;
          ST_UNL2: begin
            if (cmd_at_555 && cmd == C_A0)      st <= ST_PGM;
            else if (cmd_at_555 && cmd == C_80) st <= ST_ERS1;
            else if (cmd_at_555 && cmd == C_20) begin
              st  <= ST_BYP;
              byp <= 1'b1;
            end else st <= ST_READ;
          end
          ST_PGM: begin
            busy      <= 1'b1;
            tog       <= 1'b0;
            job_op    <= OP_PGM;
            job_addr  <= addr;
            job_data  <= dq_in;
            busy_main <= addr < BOOT_BASE;
            busy_boot <= addr >= BOOT_BASE;
            st        <= byp ? ST_BYP : ST_READ;
          end
          ST_ERS1: st <= (cmd_at_555 && cmd == C_AA) ? ST_ERS2 : ST_READ;
          ST_ERS2: st <= (addr == A_2AA && cmd == C_55) ? ST_ERS3 : ST_READ;
          ST_ERS3: begin
            st <= ST_READ;
            if (cmd == C_30) begin
              busy      <= 1'b1;
              tog       <= 1'b0;
              job_op    <= OP_SEC;
              job_addr  <= sec_lo(addr);
              job_data  <= '0;
              clr_ptr   <= sec_lo(addr);
              clr_hi    <= sec_hi(addr);
              busy_main <= addr < BOOT_BASE;
              busy_boot <= addr >= BOOT_BASE;
            end else if (cmd_at_555 && cmd == C_10) begin
              busy      <= 1'b1;
              tog       <= 1'b0;
              job_op    <= OP_CHIP;
              job_addr  <= '0;
              job_data  <= '0;
              clr_ptr   <= '0;
              clr_hi    <= LAST_WORD;
              busy_main <= 1'b1;
              busy_boot <= 1'b1;
            end
          end
          ST_BYP: begin
            if (cmd == C_A0)      st <= ST_PGM;
            else if (cmd == C_90) st <= ST_BYPX;
          end
          ST_BYPX: begin
            if (cmd == C_00) begin
              st  <= ST_READ;
              byp <= 1'b0;
            end else st <= ST_BYP;
          end
          default: st <= ST_READ;
        endcase
      end
    end
  end
endmodule

module dual_bank_flash_cmd_chk #(
  parameter int AW = 11,
  parameter int BOOT_BASE = 1792
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen,
  input logic          oen,
  input logic [AW-1:0] addr,
  input logic [15:0]   dq_out,
  input logic          ry_by,
  input logic          job_req,
  input logic [1:0]    job_op,
  input logic [AW-1:0] job_addr,
  input logic [15:0]   job_data,
  input logic          job_done
);
  localparam logic [AW-1:0] BB = AW'(BOOT_BASE);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (ry_by && !job_req));

  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    job_req |-> !ry_by);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (job_req && !job_done) |=> (job_req && $stable(job_addr) && $stable(job_op) && $stable(job_data)));

  a_r6_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !oen && job_req && job_op == 2'b01 && ((addr >= BB) == (job_addr >= BB)))
      |-> (dq_out[7] == !job_data[7] && dq_out[15:8] == 8'h00));

  a_r7_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ry_by) |-> !job_req);
endmodule

bind dual_bank_flash_cmd dual_bank_flash_cmd_chk #(.AW(11), .BOOT_BASE(BIG_TOTAL)) i_chk (
  .clk(clk), .rst_n(rst_n), .cen(cen), .oen(oen), .addr(addr), .dq_out(dq_out),
  .ry_by(ry_by), .job_req(job_req), .job_op(job_op), .job_addr(job_addr),
  .job_data(job_data), .job_done(job_done)
);

// File: tb/test_dual_bank_flash_cmd.sv
module test_dual_bank_flash_cmd;
  localparam int WORDS = 2048;
  localparam int BOOT = 1792;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cen = 1'b1, wen = 1'b1, oen = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe, ry_by, job_req, job_done;
  logic [1:0] job_op;
  logic [10:0] job_addr;
  logic [15:0] job_data;
  logic release_job = 1'b0;
  logic [15:0] mdl [WORDS];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_bank_flash_cmd i_dual_bank_flash_cmd (
    .clk(clk), .rst_n(rst_n), .cen(cen), .wen(wen), .oen(oen), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by),
    .job_req(job_req), .job_op(job_op), .job_addr(job_addr), .job_data(job_data),
    .job_done(job_done)
  );

  initial job_done = 1'b0;
  always @(negedge clk) job_done <= job_req && release_job && !job_done;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk) addr = a; dq_in = d; cen = 1'b0; wen = 1'b0;
    @(negedge clk) wen = 1'b1;
    @(negedge clk) cen = 1'b1;
  endtask

  task automatic bw_nocs(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk) addr = a; dq_in = d; wen = 1'b0;
    @(negedge clk) wen = 1'b1;
    @(negedge clk);
  endtask

  task automatic br(input logic [10:0] a, output logic [15:0] v);
    @(negedge clk) addr = a; cen = 1'b0; oen = 1'b0;
    @(negedge clk) v = dq_out; oen = 1'b1;
    @(negedge clk) cen = 1'b1;
  endtask

  task automatic prog4(input logic [10:0] a, input logic [15:0] d);
    bw(11'h555, 16'h00AA); bw(11'h2AA, 16'h0055); bw(11'h555, 16'h00A0); bw(a, d);
  endtask

  task automatic erase_pre();
    bw(11'h555, 16'h00AA); bw(11'h2AA, 16'h0055); bw(11'h555, 16'h0080);
    bw(11'h555, 16'h00AA); bw(11'h2AA, 16'h0055);
  endtask

  task automatic finish_job(input string req);
    int n = 0;
    release_job = 1'b1;
    while (!ry_by && n < 5000) begin @(negedge clk); n++; end
    release_job = 1'b0;
    chk(req, {31'd0, ry_by}, 32'd1);
  endtask

  task automatic sweep_all(input string req);
    logic [15:0] v;
    for (int a = 0; a < WORDS; a++) begin
      br(11'(a), v);
      chk(req, {16'd0, v}, {16'd0, mdl[a]});
    end
  endtask

  function automatic logic [15:0] pstat(input logic [15:0] d, input logic t);
    return {8'h00, ~d[7], t, 6'h00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [10:0] a, o;
    logic [15:0] d;
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", {31'd0, ry_by}, 32'd1);
    chk("R1 no request in reset", {31'd0, job_req}, 32'd0);
    chk("R1 bus not driven", {31'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 chip erase
    erase_pre(); bw(11'h555, 16'h0010);
    chk("R4 chip erase op", {29'd0, job_req, job_op}, {29'd0, 1'b1, 2'b11});
    chk("R2 busy low", {31'd0, ry_by}, 32'd0);
    br(11'd5, v);    chk("R6 erase status first", {16'd0, v}, 32'h0000);
    br(11'd1900, v); chk("R6 erase status toggled", {16'd0, v}, 32'h0040);
    finish_job("R7 chip erase completes");
    for (int i = 0; i < WORDS; i++) mdl[i] = 16'hFFFF;
    sweep_all("R4 chip erased");

    // R2 R3 R5 R6 R7 R10 program sweep
    for (int i = 0; i < 48; i++) begin
      a = 11'((i * 173 + 11) % WORDS);
      d = 16'((i * 16'h3B5D) ^ 16'h5A5A);
      o = (a >= 11'(BOOT)) ? 11'(a % BOOT) : 11'(BOOT + (a % 256));
      prog4(a, d);
      chk("R2 request", {29'd0, job_req, job_op}, {29'd0, 1'b1, 2'b01});
      chk("R2 addr/data", {5'd0, job_addr, job_data}, {5'd0, a, d});
      br(o, v); chk("R5 other bank array", {16'd0, v}, {16'd0, mdl[o]});
      br(a, v); chk("R6 status first read", {16'd0, v}, {16'd0, pstat(d, 1'b0)});
      br(a, v); chk("R6 status second read", {16'd0, v}, {16'd0, pstat(d, 1'b1)});
      if (i % 8 == 0) prog4(o, 16'h0000);
      finish_job("R7 program completes");
      mdl[a] = mdl[a] & d;
      br(a, v); chk("R3 programmed word", {16'd0, v}, {16'd0, mdl[a]});
      br(o, v); chk("R10 write during busy ignored", {16'd0, v}, {16'd0, mdl[o]});
      chk("R10 no new job", {31'd0, job_req}, 32'd0);
    end
    a = 11'd11;
    prog4(a, 16'h0FF0); finish_job("R7 reprogram");
    mdl[a] = mdl[a] & 16'h0FF0;
    br(a, v); chk("R3 AND of old and new", {16'd0, v}, {16'd0, mdl[a]});

    // R4 sector erase, main bank sector 3, then boot sector 1
    for (int k = 384; k < 520; k += 9) begin
      prog4(11'(k), 16'h1234); finish_job("R7 fill"); mdl[k] = mdl[k] & 16'h1234;
    end
    prog4(11'd1830, 16'h00F0); finish_job("R7 fill"); mdl[1830] = mdl[1830] & 16'h00F0;
    prog4(11'd1860, 16'h0F00); finish_job("R7 fill"); mdl[1860] = mdl[1860] & 16'h0F00;
    erase_pre(); bw(11'd400, 16'h0030);
    chk("R4 sector erase op", {29'd0, job_req, job_op}, {29'd0, 1'b1, 2'b10});
    chk("R4 sector base", {21'd0, job_addr}, 32'd384);
    br(11'd1830, v); chk("R5 boot read during main erase", {16'd0, v}, {16'd0, mdl[1830]});
    br(11'd700, v);  chk("R6 erase status bit7 low", {16'd0, v}, 32'h0000);
    finish_job("R7 sector erase completes");
    for (int k = 384; k < 512; k++) mdl[k] = 16'hFFFF;
    erase_pre(); bw(11'd1830, 16'h0030);
    chk("R4 boot sector base", {21'd0, job_addr}, 32'd1824);
    br(11'd390, v); chk("R5 main read during boot erase", {16'd0, v}, {16'd0, mdl[390]});
    finish_job("R7 boot erase completes");
    for (int k = 1824; k < 1856; k++) mdl[k] = 16'hFFFF;
    sweep_all("R4 sector erase bounded");

    // R8 bypass
    bw(11'h555, 16'h00AA); bw(11'h2AA, 16'h0055); bw(11'h555, 16'h0020);
    for (int i = 0; i < 16; i++) begin
      a = 11'((i * 131 + 40) % WORDS);
      d = 16'(16'hF0E1 - i * 16'h0123);
      bw(11'(i), 16'h00A0); bw(a, d);
      chk("R8 bypass program", {5'd0, job_addr, job_data}, {5'd0, a, d});
      chk("R8 bypass request", {31'd0, job_req}, 32'd1);
      finish_job("R8 bypass done");
      mdl[a] = mdl[a] & d;
      br(a, v); chk("R8 bypass result", {16'd0, v}, {16'd0, mdl[a]});
    end
    bw(11'd3, 16'h0090); bw(11'd3, 16'h0000);
    bw(11'd0, 16'h00A0); bw(11'd100, 16'h0000);
    chk("R8 exited bypass", {31'd0, job_req}, 32'd0);
    br(11'd100, v); chk("R8 word untouched", {16'd0, v}, {16'd0, mdl[100]});

    // R9 mismatch and F0
    bw(11'h555, 16'h00AA); bw(11'h123, 16'h0055); bw(11'h555, 16'h00A0); bw(11'd200, 16'h0000);
    chk("R9 bad address drops", {31'd0, job_req}, 32'd0);
    bw(11'h555, 16'h00AA); bw(11'h000, 16'h00F0); bw(11'h2AA, 16'h0055);
    bw(11'h555, 16'h00A0); bw(11'd200, 16'h0000);
    chk("R9 F0 drops", {31'd0, job_req}, 32'd0);
    bw(11'h555, 16'h00AA); bw(11'h2AA, 16'h0055); bw(11'h555, 16'h0077);
    bw(11'h555, 16'h00A0); bw(11'd200, 16'h0000);
    chk("R9 bad command drops", {31'd0, job_req}, 32'd0);
    br(11'd200, v); chk("R9 word untouched", {16'd0, v}, {16'd0, mdl[200]});

    // R11 write with chip enable high
    bw(11'h555, 16'h00AA); bw_nocs(11'h2AA, 16'h0055);
    bw(11'h2AA, 16'h0055); bw(11'h555, 16'h00A0); bw(11'd250, 16'h8001);
    chk("R11 deselected write ignored", {31'd0, job_req}, 32'd1);
    finish_job("R11 done"); mdl[250] = mdl[250] & 16'h8001;

    // R1 reset abort
    prog4(11'd300, 16'h0000);
    chk("R1 job running", {31'd0, job_req}, 32'd1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 abort ready", {30'd0, ry_by, job_req}, 32'd2);
    @(negedge clk) rst_n = 1'b1;
    br(11'd300, v); chk("R1 array read after abort", {16'd0, v}, {16'd0, mdl[300]});
    bw(11'h555, 16'h00AA); bw(11'h2AA, 16'h0055); bw(11'h555, 16'h0020);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    bw(11'd0, 16'h00A0); bw(11'd301, 16'h0000);
    chk("R1 reset leaves bypass", {31'd0, job_req}, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule